// File: doc/BRIEF.md
# Write Status Bit Responder

This block supplies the byte a flash device returns on reads while an internal program or erase is running. A launch pulse from the command logic carries an operation code and, for a program, the byte being written. The block latches both and starts a busy timer whose length depends on the operation. While the timer runs, each read returns a status byte instead of array contents. Bit 7 is a completion flag, bit 6 flips on every read, and bits 5:0 are zero.

Bit 7 holds the inverse of bit 7 of the byte being programmed during a program, and holds 0 during an erase. When the timer expires the block goes idle and reads return the true array byte, so erased locations read 0xFF. Software can detect the end of a program or erase by polling either status bit. Program, sector-erase and chip-erase durations are separate clock-count parameters.

Top module: `write_status_responder`

## Requirements
- R1: A launch with a valid operation code while idle raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles, chosen by the code: 2'b01 program, 2'b10 sector erase, 2'b11 chip erase.
- R2: During a program, a read returns bit 7 equal to the inverse of bit 7 of the byte latched at launch.
- R3: During a sector or chip erase, a read returns bit 7 equal to 0.
- R4: Bit 6 of a busy read holds the toggle state, which is 0 after reset. The toggle state inverts after each busy read. Reads while idle leave it unchanged.
- R5: During any busy read, bits 5:0 are zero and array data is not returned.
- R6: A read strobe while idle loads `rd_data` with `array_data` on that clock edge. Without a strobe, `rd_data` holds its value.
- R7: A launch while busy is ignored. The operation, the latched byte and the remaining time are unchanged.
- R8: A launch with operation code 2'b00 is ignored, and `busy` stays low.
- R9: While reset is asserted, `busy` is 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch | input | 1 | One-cycle pulse that starts an operation |
| launch_op | input | 2 | Operation code: 00 none, 01 program, 10 sector erase, 11 chip erase |
| launch_byte | input | DW | Byte being programmed |
| rd_stb | input | 1 | Read strobe, one per read |
| array_data | input | DW | True array contents at the read address |
| rd_data | output | DW | Registered read data |
| busy | output | 1 | Internal operation in progress |

## Verification
Random traffic mixes program and erase launches with random bytes, so the bit 7 polarity under both operation kinds shows whether the operation type and the latched byte were captured. Back-to-back reads and reads spread across idle gaps separate a toggle that advances per strobe from one that advances per clock or during idle. Directed cases cover several conditions: a launch with code 00, a launch during busy, a read in the same cycle as the launch, and a read on the final busy cycle. These expose off-by-one timer ends and reloads of a running operation.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_SECT  = 2'b10,
    OP_CHIP  = 2'b11
  } wsr_op_e;
endpackage

// File: rtl/wsr_busy_timer.sv
module wsr_busy_timer
  import wsr_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned PROG_CYC = 4000,
  parameter int unsigned SECT_CYC = 20000,
  parameter int unsigned CHIP_CYC = 60000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [1:0]    launch_op,
  input  logic [DW-1:0] launch_byte,
  output logic          busy,
  output wsr_op_e       op_q,
  output logic [DW-1:0] byte_q
);
  localparam int unsigned MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > CHIP_CYC) ? MAX_AB : CHIP_CYC;
  localparam int unsigned CW     = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;
  logic          accept;

  assign accept = launch && !busy && (launch_op != OP_NONE);

  always_comb begin
    case (launch_op)
      OP_PROG: load_val = CW'(PROG_CYC);
      OP_SECT: load_val = CW'(SECT_CYC);
      OP_CHIP: load_val = CW'(CHIP_CYC);
      default: load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy   <= 1'b0;
      op_q   <= OP_NONE;
      byte_q <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) busy <= 1'b0;
    end else if (accept) begin
      cnt    <= load_val;
      busy   <= 1'b1;
      op_q   <= wsr_op_e'(launch_op);
      byte_q <= launch_byte;
    end
  end

  a_r1_busy_rises: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  a_r1_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == CW'(1)) |=> !busy);
  a_r7_no_reload: assert property (@(posedge clk) disable iff (rst)
    (busy && launch) |=> ($stable(op_q) && $stable(byte_q)));
  a_r8_none_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && launch && launch_op == OP_NONE) |=> !busy);
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rd_stb,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst)                 tog <= 1'b0;
    else if (busy && rd_stb) tog <= ~tog;
  end

  a_r4_flip: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_stb) |=> (tog != $past(tog)));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !(busy && rd_stb) |=> $stable(tog));
endmodule

// File: rtl/wsr_read_mux.sv
module wsr_read_mux
  import wsr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stb,
  input  logic          busy,
  input  logic          tog,
  input  wsr_op_e       op_q,
  input  logic [DW-1:0] byte_q,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned POLL_B = DW - 1;
  localparam int unsigned TOG_B  = DW - 2;

  logic [DW-1:0] status;

  always_comb begin
    status         = '0;
    status[POLL_B] = (op_q == OP_PROG) ? ~byte_q[POLL_B] : 1'b0;
    status[TOG_B]  = tog;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= busy ? status : array_data;
  end

  a_r3_erase_poll: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && busy && op_q != OP_PROG) |=> !rd_data[POLL_B]);
  a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && busy) |=> (rd_data[TOG_B-1:0] == '0));
  a_r6_idle_pass: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !busy) |=> (rd_data == $past(array_data)));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/write_status_responder.sv
module write_status_responder
  import wsr_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned PROG_CYC = 4000,
  parameter int unsigned SECT_CYC = 20000,
  parameter int unsigned CHIP_CYC = 60000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [1:0]    launch_op,
  input  logic [DW-1:0] launch_byte,
  input  logic          rd_stb,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  wsr_op_e       op_q;
  logic [DW-1:0] byte_q;
  logic          tog;

  wsr_busy_timer #(
    .DW(DW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .launch(launch), .launch_op(launch_op),
    .launch_byte(launch_byte), .busy(busy), .op_q(op_q), .byte_q(byte_q)
  );

  wsr_toggle u_tog (
    .clk(clk), .rst(rst), .busy(busy), .rd_stb(rd_stb), .tog(tog)
  );

  wsr_read_mux #(.DW(DW)) u_mux (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .busy(busy), .tog(tog),
    .op_q(op_q), .byte_q(byte_q), .array_data(array_data), .rd_data(rd_data)
  );

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (!busy && rd_data == '0));
endmodule

// File: tb/test_write_status_responder.sv
`timescale 1ns/1ps
module test_write_status_responder;
  localparam int unsigned PC = 40;
  localparam int unsigned SC = 90;
  localparam int unsigned CC = 170;

  logic       clk = 1'b0;
  logic       rst;
  logic       launch;
  logic [1:0] launch_op;
  logic [7:0] launch_byte;
  logic       rd_stb;
  logic [7:0] array_data;
  logic [7:0] rd_data;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit       m_busy = 0;
  int       m_cnt  = 0;
  bit [1:0] m_op   = 0;
  bit [7:0] m_pd   = 0;
  bit       m_tog  = 0;
  bit [7:0] m_rd   = 0;
  string    m_tag  = "R6";

  always #2.5 clk = ~clk;

  write_status_responder #(
    .DW(8), .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC)
  ) i_write_status_responder (
    .clk(clk), .rst(rst), .launch(launch), .launch_op(launch_op),
    .launch_byte(launch_byte), .rd_stb(rd_stb), .array_data(array_data),
    .rd_data(rd_data), .busy(busy)
  );

  function automatic int dur_of(input bit [1:0] op);
    case (op)
      2'b01:   return PC;
      2'b10:   return SC;
      2'b11:   return CC;
      default: return 0;
    endcase
  endfunction

  function automatic bit [7:0] status_of(input bit [1:0] op, input bit [7:0] pd, input bit t);
    bit [7:0] s;
    s    = 8'h00;               // R5: low bits zero
    s[7] = (op == 2'b01) ? ~pd[7] : 1'b0;  // R2 / R3
    s[6] = t;                   // R4
    return s;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input bit s, input bit [1:0] o, input bit [7:0] p,
                     input bit r, input bit [7:0] a);
    launch = s; launch_op = o; launch_byte = p; rd_stb = r; array_data = a;
    @(posedge clk);
    if (r) begin
      if (m_busy) begin
        m_rd  = status_of(m_op, m_pd, m_tog);
        m_tag = (m_op == 2'b01) ? "R2/R4/R5" : "R3/R4/R5";
        m_tog = ~m_tog;
      end else begin
        m_rd  = a;
        m_tag = "R6";
      end
    end else begin
      m_tag = "R6 hold";
    end
    if (m_busy) begin
      if (m_cnt == 1) m_busy = 0;
      m_cnt--;
    end else if (s && o != 2'b00) begin   // R7, R8: only idle, valid codes accepted
      m_busy = 1; m_cnt = dur_of(o); m_op = o; m_pd = p;
    end
    @(negedge clk);
    check8(m_tag, rd_data, m_rd);
    check1("R1 busy", busy, m_busy);
  endtask

  initial begin
    rst = 1; launch = 0; launch_op = 0; launch_byte = 0; rd_stb = 0; array_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R9 busy", busy, 1'b0);
    check8("R9 rd_data", rd_data, 8'h00);
    rst = 0;

    // R8: code 00 ignored
    cyc(1, 2'b00, 8'h00, 0, 8'h00);
    check1("R8", busy, 1'b0);
    // R6: idle passthrough, erased byte
    cyc(0, 0, 0, 1, 8'hFF);
    cyc(0, 0, 0, 1, 8'h3C);
    cyc(0, 0, 0, 0, 8'h11);
    // read in the launch cycle sees idle data, then program with bit7=1
    cyc(1, 2'b01, 8'hA5, 1, 8'h5A);
    // R7: launch while busy with different op and byte
    cyc(1, 2'b11, 8'h00, 1, 8'h00);
    cyc(0, 0, 0, 1, 8'h00);   // R2: expect bit7=0, toggles
    while (m_busy) cyc(0, 0, 0, (m_cnt == 1), 8'h77); // read on final busy cycle
    cyc(0, 0, 0, 1, 8'hA5);   // R6: true data after end
    // sector erase, back-to-back reads
    cyc(1, 2'b10, 8'h00, 0, 8'h00);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 8'h00);
    while (m_busy) cyc(0, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hFF);   // erased reads 0xFF

    // random traffic, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      bit s; bit [1:0] o; bit [7:0] p; bit r; bit [7:0] a;
      s = (($urandom % 40) == 0);
      o = 2'($urandom);
      p = 8'($urandom);
      r = (($urandom % 3) != 0);
      a = 8'($urandom);
      cyc(s, o, p, r, a);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule